// File: doc/BRIEF.md
# Selectable Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial link (bit clock, word clock and one data line) and turns it into parallel samples. Data arrive MSB first in two's complement. The word clock runs at the sample rate and carries one left slot and one right slot per period. The receiver runs on the bit clock itself. It samples the word clock and the data on every rising edge, finds word clock transitions on its own, and counts bit positions inside each slot.

A static three-bit select input picks one of six framings. Three are right-justified (16, 20 or 24 bits), one is left-justified (24 bits) and two are I2S (16 or 24 bits). The two remaining codes are reserved. Each channel word is placed at the top of a 24-bit output with zeros below it. When the right word of a stereo pair is complete, both words appear on the outputs together with a one-cycle strobe. Moving the pair into a system clock domain is left to the consumer, which sees the strobe and the held pair.

Top module: `ser_audio_rx`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, both sample outputs read zero and the pair strobe and the error flag are low.
- R2: sel_i is {width bit 1, width bit 0, I2S bit} in bit positions 2, 1 and 0. Codes 000, 010 and 100 select right-justified words of 16, 20 and 24 bits. The word is the last W bits sampled before the word clock changes level, with its LSB in the final bit period of the slot. Bits sampled earlier in the slot have no effect on the output.
- R3: A 16-bit or 20-bit word appears in bits 23 down to 8 or 23 down to 4 of its output, and every bit below it is zero.
- R4: Code 110 selects 24-bit left-justified framing. The MSB is sampled on the same rising bit clock edge at which the new word clock level is first seen. Bits after the 24th have no effect.
- R5: Codes 001 and 011 select I2S framing with 16-bit or 24-bit words. The MSB is sampled one bit period after the word clock edge. Bits after the word have no effect.
- R6: In the right-justified and left-justified framings, a slot with the word clock high carries the left channel. In I2S framing, a slot with the word clock low carries the left channel.
- R7: Once a right word is complete, pair_valid_o is high for exactly one cycle and left_o/right_o hold the preceding left word and that right word. A right word with no left word captured since reset or since the last pair produces no strobe. The outputs hold their values between strobes.
- R8: Codes 101 and 111 are reserved. One cycle after such a code is applied, sel_err_o is high, and every pair delivered under it carries zero on both outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lrclk_i | input | 1 | Word clock marking left and right slots |
| sdata_i | input | 1 | Serial data, MSB first |
| sel_i | input | 3 | Static framing select {width1, width0, i2s} |
| left_o | output | 24 | Left sample of the last completed pair, left-aligned |
| right_o | output | 24 | Right sample of the last completed pair, left-aligned |
| pair_valid_o | output | 1 | One-cycle strobe when a new pair is on the outputs |
| sel_err_o | output | 1 | High while a reserved select code is applied |

## Verification
Every framing is run with 32-bit slots. The filler bits outside the word are driven to ones, so extracting at the wrong position or failing to clear low bits shows up as set bits in the output. The sample values include a lone MSB, the largest positive value, a value of one, all ones and pseudo-random words. These tell apart bit order, sign handling and an off-by-one in the capture point. Left and right words always differ, so swapped word clock polarity is visible. A lead-in slot at the right level before the first left slot checks that a right word with no left partner is dropped. The reserved codes are checked for zero pairs and for the error flag.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int SAMPLE_W = 24;
    localparam int LEN_W    = 5;

    typedef enum logic [1:0] {
        FMT_RIGHT = 2'd0,
        FMT_LEFT  = 2'd1,
        FMT_I2S   = 2'd2
    } frame_fmt_e;

    typedef struct packed {
        frame_fmt_e          fmt;
        logic [LEN_W-1:0]    wlen;
        logic                reserved;
        logic                left_on_high;
    } rx_cfg_t;

    // Select code layout: {width1, width0, i2s}
    function automatic rx_cfg_t decode_select(input logic [2:0] code);
        rx_cfg_t c;
        c.fmt          = FMT_RIGHT;
        c.wlen         = LEN_W'(24);
        c.reserved     = 1'b0;
        c.left_on_high = 1'b1;
        case (code)
            3'b000: c.wlen = LEN_W'(16);
            3'b010: c.wlen = LEN_W'(20);
            3'b100: c.wlen = LEN_W'(24);
            3'b110: c.fmt  = FMT_LEFT;
            3'b001: begin
                c.fmt          = FMT_I2S;
                c.wlen         = LEN_W'(16);
                c.left_on_high = 1'b0;
            end
            3'b011: begin
                c.fmt          = FMT_I2S;
                c.left_on_high = 1'b0;
            end
            default: begin
                c.reserved     = 1'b1;
                c.left_on_high = 1'b0;
            end
        endcase
        return c;
    endfunction

    // Move the low wlen bits of raw to the top of the sample, zero below.
    function automatic logic [SAMPLE_W-1:0] justify_word(
        input logic [SAMPLE_W-1:0] raw,
        input logic [LEN_W-1:0]    wlen
    );
        logic [LEN_W-1:0] sh;
        sh = LEN_W'(SAMPLE_W) - wlen;
        return raw << sh;
    endfunction

endpackage

// File: rtl/sar_mode_decode.sv
module sar_mode_decode
    import sar_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    sel_i,
    output rx_cfg_t       cfg_o,
    output logic          err_o
);

    rx_cfg_t cfg_q;
    logic    err_q;

    // The configuration loads even in reset, so it is valid on release.
    always_ff @(posedge clk) begin
        cfg_q <= decode_select(sel_i);
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= cfg_q.reserved;
    end

    assign cfg_o = cfg_q;
    assign err_o = err_q;

endmodule

// File: rtl/sar_frame_tracker.sv
module sar_frame_tracker #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lrclk_i,
    output logic             edge_o,
    output logic             prev_level_o,
    output logic [CNT_W-1:0] idx_o
);

    localparam logic [CNT_W-1:0] POS_MAX = '1;

    logic             lr_q;
    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] idx;
    logic             edge_now;

    assign edge_now = (lrclk_i != lr_q);
    assign idx      = edge_now ? '0 : pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lr_q  <= lrclk_i;
            pos_q <= POS_MAX;
        end else begin
            lr_q  <= lrclk_i;
            pos_q <= (idx == POS_MAX) ? POS_MAX : idx + CNT_W'(1);
        end
    end

    assign edge_o       = edge_now;
    assign prev_level_o = lr_q;
    assign idx_o        = idx;

    // R4: bit index restarts at the word clock edge and counts up after it
    a_r4_index_after_edge: assert property (@(posedge clk) disable iff (rst)
        (edge_o && !$past(rst)) |=> (idx_o == CNT_W'(1) || edge_o));

endmodule

// File: rtl/sar_word_extract.sv
module sar_word_extract
    import sar_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  rx_cfg_t             cfg_i,
    input  logic                sdata_i,
    input  logic                lrclk_i,
    input  logic                edge_i,
    input  logic                prev_level_i,
    input  logic [CNT_W-1:0]    idx_i,
    output logic                cap_o,
    output logic                cap_left_o,
    output logic [SAMPLE_W-1:0] word_o
);

    logic [SAMPLE_W-1:0] sr_q;
    logic [SAMPLE_W-1:0] raw;
    logic [CNT_W-1:0]    tgt;
    logic                is_i2s;
    logic                level;
    logic                cap;

    always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= {sr_q[SAMPLE_W-2:0], sdata_i};
    end

    assign is_i2s = (cfg_i.fmt == FMT_I2S);
    // LSB position in the slot: wlen-1, shifted by one for I2S framing.
    assign tgt = CNT_W'(cfg_i.wlen) - CNT_W'(1) + CNT_W'(is_i2s);

    always_comb begin
        if (cfg_i.fmt == FMT_RIGHT) begin
            // Slot just ended: history already holds its last bits.
            cap   = edge_i;
            raw   = sr_q;
            level = prev_level_i;
        end else begin
            cap   = (idx_i == tgt);
            raw   = {sr_q[SAMPLE_W-2:0], sdata_i};
            level = lrclk_i;
        end
    end

    assign cap_o      = cap;
    assign cap_left_o = cfg_i.left_on_high ? level : ~level;
    assign word_o     = cfg_i.reserved ? '0 : justify_word(raw, cfg_i.wlen);

    // R5: counted captures never fall on a word clock edge
    a_r5_capture_off_edge: assert property (@(posedge clk) disable iff (rst)
        (cap_o && cfg_i.fmt != FMT_RIGHT) |-> !edge_i);

endmodule

// File: rtl/ser_audio_rx.sv
module ser_audio_rx
    import sar_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lrclk_i,
    input  logic                sdata_i,
    input  logic [2:0]          sel_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                pair_valid_o,
    output logic                sel_err_o
);

    rx_cfg_t             cfg;
    logic                err;
    logic                edge_w;
    logic                prev_level;
    logic [CNT_W-1:0]    idx;
    logic                cap;
    logic                cap_left;
    logic [SAMPLE_W-1:0] word;

    logic [SAMPLE_W-1:0] left_hold_q;
    logic                left_seen_q;
    logic [SAMPLE_W-1:0] left_q;
    logic [SAMPLE_W-1:0] right_q;
    logic                valid_q;

    sar_mode_decode u_decode (
        .clk   (clk),
        .rst   (rst),
        .sel_i (sel_i),
        .cfg_o (cfg),
        .err_o (err)
    );

    sar_frame_tracker #(.CNT_W(CNT_W)) u_track (
        .clk          (clk),
        .rst          (rst),
        .lrclk_i      (lrclk_i),
        .edge_o       (edge_w),
        .prev_level_o (prev_level),
        .idx_o        (idx)
    );

    sar_word_extract #(.CNT_W(CNT_W)) u_extract (
        .clk          (clk),
        .rst          (rst),
        .cfg_i        (cfg),
        .sdata_i      (sdata_i),
        .lrclk_i      (lrclk_i),
        .edge_i       (edge_w),
        .prev_level_i (prev_level),
        .idx_i        (idx),
        .cap_o        (cap),
        .cap_left_o   (cap_left),
        .word_o       (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            left_hold_q <= '0;
            left_seen_q <= 1'b0;
            left_q      <= '0;
            right_q     <= '0;
            valid_q     <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (cap && cap_left) begin
                left_hold_q <= word;
                left_seen_q <= 1'b1;
            end else if (cap && left_seen_q) begin
                left_q      <= left_hold_q;
                right_q     <= word;
                valid_q     <= 1'b1;
                left_seen_q <= 1'b0;
            end
        end
    end

    assign left_o       = left_q;
    assign right_o      = right_q;
    assign pair_valid_o = valid_q;
    assign sel_err_o    = err;

    // R1: outputs are clear in the first cycle after reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!pair_valid_o && !sel_err_o && left_o == '0 && right_o == '0));

    // R7: a pair strobe lasts a single cycle
    a_r7_strobe_single: assert property (@(posedge clk) disable iff (rst)
        pair_valid_o |=> !pair_valid_o);

    // R7: a right word without a left partner raises no strobe
    a_r7_orphan_right: assert property (@(posedge clk) disable iff (rst)
        (cap && !cap_left && !left_seen_q) |=> !pair_valid_o);

    // R8: pairs delivered under a reserved code are zero
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (pair_valid_o && sel_err_o) |-> (left_o == '0 && right_o == '0));

    // R3: bits below the selected word length are zero
    a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (pair_valid_o && !$past(rst)) |->
            (SAMPLE_W'(left_o << $past(cfg.wlen)) == '0 &&
             SAMPLE_W'(right_o << $past(cfg.wlen)) == '0));

endmodule

// File: tb/ser_audio_rx_tb_top.sv
module ser_audio_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lrclk = 1'b0;
    logic        sdata = 1'b0;
    logic [2:0]  sel = 3'b000;
    logic [23:0] left_w;
    logic [23:0] right_w;
    logic        pair_valid;
    logic        sel_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    typedef struct {
        logic [23:0] l;
        logic [23:0] r;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    ser_audio_rx dut_i (
        .clk          (clk),
        .rst          (rst),
        .lrclk_i      (lrclk),
        .sdata_i      (sdata),
        .sel_i        (sel),
        .left_o       (left_w),
        .right_o      (right_w),
        .pair_valid_o (pair_valid),
        .sel_err_o    (sel_err)
    );

    // Monitor: pop one expected pair per strobe
    always @(negedge clk) begin
        exp_t e;
        if (!rst && pair_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R7 unexpected pair: actual left=%h right=%h, expected no strobe",
                         left_w, right_w);
            end else begin
                e = exp_q.pop_front();
                if (left_w !== e.l || right_w !== e.r) begin
                    fails++;
                    $display("FAIL %s pair: actual left=%h right=%h, expected left=%h right=%h",
                             e.tag, left_w, right_w, e.l, e.r);
                end
            end
        end
    end

    function automatic logic slot_bit(input int fmt, input int wl,
                                      input logic [23:0] w, input int i);
        if (fmt == 0) return (i >= 32 - wl) ? w[wl - 1 - (i - (32 - wl))] : 1'b1;
        if (fmt == 1) return (i < wl) ? w[wl - 1 - i] : 1'b1;
        return (i >= 1 && i <= wl) ? w[wl - i] : 1'b1;
    endfunction

    function automatic logic [31:0] step(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic drive_slot(input logic lvl, input int fmt, input int wl,
                              input logic [23:0] w);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            lrclk = lvl;
            sdata = slot_bit(fmt, wl, w, i);
        end
    endtask

    task automatic check(input string tag, input logic ok, input logic [47:0] act,
                         input logic [47:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h, expected %h", tag, act, expv);
        end
    endtask

    task automatic run_mode(input logic [2:0] code, input int fmt, input int wl,
                            input logic left_lvl, input bit rsvd, input string tag);
        logic [23:0] lw;
        logic [23:0] rw;
        logic [23:0] mask;
        exp_t e;
        @(negedge clk);
        rst   = 1'b1;
        sel   = code;
        lrclk = ~left_lvl;
        sdata = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: clear state right after reset
        check("R1 reset state", (left_w == 0 && right_w == 0 && !pair_valid && !sel_err),
              {left_w, right_w}, 48'h0);
        // lead-in slot at the right level: its word has no left partner (R7)
        drive_slot(~left_lvl, fmt, wl, 24'hFFFFFF);
        mask = 24'hFFFFFF >> (24 - wl);
        for (int f = 0; f < 6; f++) begin
            case (f)
                0: begin lw = 24'h1 << (wl - 1); rw = mask; end
                1: begin lw = mask >> 1; rw = 24'h1; end
                default: begin
                    rng = step(rng); lw = rng[23:0] & mask;
                    rng = step(rng); rw = rng[23:0] & mask;
                end
            endcase
            e.l   = rsvd ? 24'h0 : (lw << (24 - wl));
            e.r   = rsvd ? 24'h0 : (rw << (24 - wl));
            e.tag = tag;
            exp_q.push_back(e);
            drive_slot(left_lvl, fmt, wl, lw);
            drive_slot(~left_lvl, fmt, wl, rw);
        end
        drive_slot(left_lvl, fmt, wl, 24'hFFFFFF);
        repeat (4) @(negedge clk);
        check({tag, " R7 all pairs delivered"}, exp_q.size() == 0,
              48'(exp_q.size()), 48'h0);
        check({tag, " R8 error flag"}, sel_err == rsvd, 48'(sel_err), 48'(rsvd));
        exp_q.delete();
    endtask

    initial begin
        run_mode(3'b000, 0, 16, 1'b1, 1'b0, "R2 R3 R6 rj16");
        run_mode(3'b010, 0, 20, 1'b1, 1'b0, "R2 R3 rj20");
        run_mode(3'b100, 0, 24, 1'b1, 1'b0, "R2 R6 rj24");
        run_mode(3'b110, 1, 24, 1'b1, 1'b0, "R4 R6 lj24");
        run_mode(3'b001, 2, 16, 1'b0, 1'b0, "R5 R3 R6 i2s16");
        run_mode(3'b011, 2, 24, 1'b0, 1'b0, "R5 R6 i2s24");
        run_mode(3'b101, 0, 24, 1'b0, 1'b1, "R8 code101");
        run_mode(3'b111, 0, 24, 1'b0, 1'b1, "R8 code111");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R7 watchdog: actual run unfinished, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule